// File: doc/BRIEF.md
# SPI Serial Clock Prescaler

This block derives the serial clock of an SPI master from the core clock. A single 8-bit prescale byte holds two fields. The first is a 4-bit linear factor. The second is a 3-bit exponent whose bits are spread over the upper half of the byte. One serial clock period lasts linear factor × 2^exponent core cycles, so any ratio from 1 up to 1920 that is a 4-bit value times a power of two can be reached.

The shift logic sits beside this block and reads three registered outputs: the clock level, a one-cycle strobe in the cycle the clock goes high, and a one-cycle strobe in the cycle it goes low. The enable is a plain level control. While it is low, the clock rests low, the internal counters stay cleared and the prescale byte is captured on every edge. While it is high, a new byte is taken only at the end of a complete serial clock period. There is no data stream at the edge of this block, so it has no valid/ready handshake.

Top module: `spi_sclk_prescaler`

## Requirements
- R1: The linear factor is byte bits 3:0. The exponent is {bit 7, bit 6, bit 4}, so bit 4 is its least significant bit. Byte bit 5 has no effect on the outputs.
- R2: With a valid setting and the enable held high, a rise_o pulse occurs every N = factor × 2^exponent core cycles.
- R3: Within each period, sclk_o is high for ceil(N/2) cycles and then low for floor(N/2) cycles. For odd N the extra cycle goes to the high phase.
- R4: rise_o is high only in the first high cycle of a period. fall_o is high only in the first low cycle, except as stated in R5.
- R5: When N = 1, sclk_o stays high and rise_o and fall_o are both high in every enabled cycle.
- R6: When the captured linear factor is 0, sclk_o, rise_o and fall_o stay low. The byte is then captured again on every edge, so a valid byte written later starts the clock one cycle after its capture.
- R7: A byte change while running does not take effect until the current period completes. The next period then uses the byte present at the edge that ends it.
- R8: While enable_i is low, all three outputs are low, the counters are cleared and the byte is captured on every edge. The first enabled edge begins a high phase together with a rise_o pulse.
- R9: During and right after an active-low asynchronous reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prescale_i | input | 8 | Packed prescale byte (linear factor and exponent) |
| enable_i | input | 1 | Runs the serial clock when high |
| sclk_o | output | 1 | Serial clock level, idles low |
| rise_o | output | 1 | One-cycle strobe in the first high cycle |
| fall_o | output | 1 | One-cycle strobe in the first low cycle |

## Verification
The bench targets the scattered exponent field. If the design packed the exponent bits in the wrong order, or read bit 5, the period of bytes such as 0xC5 and 0x21 would come out wrong. It measures period and high time for odd ratios, where an off-by-one in the half point would give the low phase the extra cycle. It also checks the ratio of 1, where the strobes must fire every cycle rather than never. It switches the byte in mid-period and runs with a zero linear factor. A design that reloaded early would cut a period short, and one that latched the zero setting would never restart. Random bytes and enable toggles are compared cycle by cycle against a model built from the requirements.

// File: rtl/spi_presc_pkg.sv
package spi_presc_pkg;
  localparam int BYTE_W = 8;
  localparam int SPR_W  = 4;
  localparam int EXP_W  = 3;
  localparam int POW_W  = (1 << EXP_W) - 1;
  localparam int POS_W  = SPR_W + POW_W;

  typedef struct packed {
    logic [EXP_W-1:0] expo;
    logic [SPR_W-1:0] lin;
  } presc_cfg_t;
endpackage

// File: rtl/spi_presc_decode.sv
module spi_presc_decode
  import spi_presc_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  output presc_cfg_t        cfg_o
);
  // exponent bit order matters: lsb sits at byte bit 4, upper two at 7:6
  always_comb begin
    cfg_o.lin  = byte_i[SPR_W-1:0];
    cfg_o.expo = {byte_i[7:6], byte_i[4]};
  end
endmodule

// File: rtl/spi_presc_ratio.sv
module spi_presc_ratio
  import spi_presc_pkg::*;
(
  input  presc_cfg_t       cfg_i,
  output logic [POS_W-1:0] total_o,
  output logic [POS_W-1:0] half_o,
  output logic             valid_o,
  output logic             unit_o
);
  always_comb begin
    total_o = POS_W'(cfg_i.lin) << cfg_i.expo;
    half_o  = POS_W'((total_o + POS_W'(1)) >> 1);
    valid_o = (cfg_i.lin != '0);
    unit_o  = (total_o == POS_W'(1));
  end
endmodule

// File: rtl/spi_presc_counter.sv
module spi_presc_counter
  import spi_presc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  presc_cfg_t       cfg_i,
  output logic [POS_W-1:0] pos_o,
  output logic             wrap_o
);
  logic [SPR_W-1:0] lin_q;
  logic [POW_W-1:0] pw_q;
  logic [POW_W-1:0] pw_top;
  logic             pw_end;
  logic             lin_end;

  always_comb begin
    pw_top  = ~({POW_W{1'b1}} << cfg_i.expo);
    pw_end  = (pw_q == pw_top);
    lin_end = (lin_q == cfg_i.lin - SPR_W'(1));
    wrap_o  = pw_end && lin_end;
    pos_o   = (POS_W'(lin_q) << cfg_i.expo) | POS_W'(pw_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lin_q <= '0;
      pw_q  <= '0;
    end else if (clear_i) begin
      lin_q <= '0;
      pw_q  <= '0;
    end else if (step_i) begin
      if (pw_end) begin
        pw_q  <= '0;
        lin_q <= lin_end ? '0 : lin_q + SPR_W'(1);
      end else begin
        pw_q  <= pw_q + POW_W'(1);
      end
    end
  end

  assert_pw_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pw_q <= pw_top);
  assert_lin_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.lin != '0) |-> (lin_q < cfg_i.lin));
  assert_wrap_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clear_i && wrap_o) |=> (pos_o == '0));
endmodule

// File: rtl/spi_presc_phase.sv
module spi_presc_phase
  import spi_presc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [POS_W-1:0] half_i,
  input  logic             unit_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic sclk_d, rise_d, fall_d;

  always_comb begin
    sclk_d = run_i && (pos_i < half_i);
    rise_d = run_i && (pos_i == '0);
    fall_d = run_i && ((pos_i == half_i) || unit_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_o <= 1'b0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      sclk_o <= sclk_d;
      rise_o <= rise_d;
      fall_o <= fall_d;
    end
  end

  assert_rise_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> sclk_o);
  assert_fall_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_o && !rise_o) |-> !sclk_o);
endmodule

// File: rtl/spi_sclk_prescaler.sv
module spi_sclk_prescaler
  import spi_presc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] prescale_i,
  input  logic              enable_i,
  output logic              sclk_o,
  output logic              rise_o,
  output logic              fall_o
);
  presc_cfg_t       cfg_in;
  presc_cfg_t       cfg_q;
  logic [POS_W-1:0] total;
  logic [POS_W-1:0] half;
  logic [POS_W-1:0] pos;
  logic             cfg_valid;
  logic             unit;
  logic             wrap;
  logic             run;
  logic             load_cfg;

  spi_presc_decode u_decode (
    .byte_i (prescale_i),
    .cfg_o  (cfg_in)
  );

  spi_presc_ratio u_ratio (
    .cfg_i   (cfg_q),
    .total_o (total),
    .half_o  (half),
    .valid_o (cfg_valid),
    .unit_o  (unit)
  );

  always_comb begin
    run      = enable_i && cfg_valid;
    load_cfg = !run || wrap;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (load_cfg) cfg_q <= cfg_in;
  end

  spi_presc_counter u_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (!run),
    .step_i  (run),
    .cfg_i   (cfg_q),
    .pos_o   (pos),
    .wrap_o  (wrap)
  );

  spi_presc_phase u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .pos_i  (pos),
    .half_i (half),
    .unit_i (unit),
    .sclk_o (sclk_o),
    .rise_o (rise_o),
    .fall_o (fall_o)
  );

  assert_idle_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!sclk_o && !rise_o && !fall_o));
  assert_zero_factor_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !cfg_valid) |=> (!sclk_o && !rise_o && !fall_o));
  assert_cfg_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && cfg_valid && !wrap) |=> $stable(cfg_q));
  assert_unit_rate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && cfg_valid && unit) |=> (sclk_o && rise_o && fall_o));
  assert_rise_on_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> rise_o);
endmodule

// File: tb/spi_sclk_prescaler_tb.sv
module spi_sclk_prescaler_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] pres = 8'h00;
  logic       sclk, rise, fall;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_pos = 0, m_lin = 0, m_exp = 0;
  bit e_sclk = 0, e_rise = 0, e_fall = 0;

  always #2 clk = ~clk;

  spi_sclk_prescaler u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .prescale_i (pres),
    .enable_i   (en),
    .sclk_o     (sclk),
    .rise_o     (rise),
    .fall_o     (fall)
  );

  function automatic int lin_of(logic [7:0] b);
    return int'(b[3:0]);
  endfunction

  function automatic int exp_of(logic [7:0] b);
    return int'({b[7:6], b[4]});
  endfunction

  task automatic capture();
    m_lin = lin_of(pres);
    m_exp = exp_of(pres);
  endtask

  task automatic model_edge();
    if (!rst_n) begin
      m_pos = 0; m_lin = 0; m_exp = 0;
      e_sclk = 0; e_rise = 0; e_fall = 0;
    end else if (!en || m_lin == 0) begin
      m_pos = 0;
      e_sclk = 0; e_rise = 0; e_fall = 0;
      capture();
    end else begin
      int n = m_lin << m_exp;
      int h = (n + 1) / 2;
      e_sclk = (m_pos < h);
      e_rise = (m_pos == 0);
      e_fall = (m_pos == h) || (n == 1);
      if (m_pos == n - 1) begin
        m_pos = 0;
        capture();
      end else begin
        m_pos++;
      end
    end
  endtask

  task automatic check_bit(string tag, string what, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b (pres=%h)", tag, what, act, expv, pres);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_bit(tag, "sclk", sclk, e_sclk);
    check_bit(tag, "rise", rise, e_rise);
    check_bit(tag, "fall", fall, e_fall);
  endtask

  task automatic steps(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic check_int(string tag, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // start from disabled, run and measure one full period after the first rise
  task automatic measure(logic [7:0] b, int exp_period, int exp_high, string tag);
    int period;
    int high;
    en = 1'b0;
    pres = b;
    steps(2, tag);
    en = 1'b1;
    step(tag);
    check_bit(tag, "first rise", rise, 1'b1);
    period = 1;
    high = sclk ? 1 : 0;
    for (int i = 0; i < 4000; i++) begin
      step(tag);
      if (rise) break;
      period++;
      if (sclk) high++;
    end
    check_int(tag, "period", period, exp_period);
    check_int(tag, "high cycles", high, exp_high);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1234);

    // R9: reset state
    repeat (3) @(negedge clk);
    check_bit("R9", "sclk in reset", sclk, 1'b0);
    check_bit("R9", "rise in reset", rise, 1'b0);
    check_bit("R9", "fall in reset", fall, 1'b0);
    rst_n = 1'b1;
    steps(2, "R9");

    // R1 and R5: bit 5 ignored, ratio of one
    pres = 8'h21;
    steps(2, "R8");
    en = 1'b1;
    steps(6, "R5");
    en = 1'b0;
    pres = 8'h01;
    steps(2, "R8");
    en = 1'b1;
    steps(4, "R1");

    // R3 / R2 with small and large ratios
    measure(8'h02, 2, 1, "R3");
    measure(8'h0F, 15, 8, "R3");
    measure(8'h13, 6, 3, "R1");
    measure(8'h41, 4, 2, "R1");
    measure(8'hC5, 320, 160, "R2");
    measure(8'h3B, 22, 11, "R1");
    measure(8'hDF, 1920, 960, "R2");

    // R6: zero linear factor, then recovery while enabled
    en = 1'b0;
    pres = 8'h70;
    steps(2, "R6");
    en = 1'b1;
    steps(12, "R6");
    pres = 8'h03;
    steps(10, "R6");

    // R7: byte change mid-period
    en = 1'b0;
    pres = 8'h07;
    steps(2, "R7");
    en = 1'b1;
    steps(3, "R7");
    pres = 8'h02;
    steps(16, "R7");
    pres = 8'h15;
    steps(30, "R7");

    // R8: disable in the middle of a high phase, then restart
    en = 1'b0;
    steps(3, "R8");
    en = 1'b1;
    step("R8");
    check_bit("R8", "restart rise", rise, 1'b1);
    steps(5, "R8");

    // random bytes, enable toggles and mid-run changes
    for (int r = 0; r < 30; r++) begin
      pres = 8'($urandom);
      if ($urandom % 4 == 0) en = ~en;
      steps(1 + int'($urandom % 600), "R2");
      if ($urandom % 2 == 0) begin
        pres = 8'($urandom);
        steps(1 + int'($urandom % 200), "R7");
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule